// File: doc/BRIEF.md
# Three-Channel Wiper Register Controller

This block keeps the wiper codes of three digitally controlled resistor channels. Two channels are 9 bits wide (codes 0 to 511) and one is 7 bits wide (codes 0 to 127). Each channel has a working register that drives its wiper output, and a nonvolatile slot, modelled here as a plain register, that holds the value the working register returns to on a restore.

Commands arrive already deframed from a serial bus: a valid strobe with a 7-bit device address, an opcode, a channel number and a data word. Wiper operations answer to one device address. Store and restore operations answer to a second device address. The upper five bits of each address are parameters, and the lower two come from strap pins. The block can overwrite a wiper, read it back, step it linearly or by a factor of two, save it to its slot, or restore it from its slot. An active-low write-protect pin freezes every change except restores. A reload pin restores all three channels at once.

Top module: `wiper_ctrl_top`

## Requirements
- R1: While `rst` is high, every slot and every working register is set to midscale: 256 for the 9-bit channels and 64 for the 7-bit channel. `busy` and `rd_valid` are low at the first clock edge after `rst` is released.
- R2: Opcode 1 (write) sets the working register of the selected channel at the next clock edge. A data value above the channel's full scale (511, or 127 for channel 2) is stored as full scale.
- R3: Opcode 2 (read) makes `rd_valid` high for exactly the cycle after the command. In that cycle `rd_data` holds the selected working register, zero-extended to 9 bits. `rd_valid` is low in every other cycle.
- R4: Opcodes 5 (up) and 6 (down) change the selected wiper by one code. The result stops at full scale when stepping up and at zero when stepping down.
- R5: Opcode 7 shifts the code left and fills the low bit with 1. Opcode 8 shifts the code right. A result above full scale becomes full scale.
- R6: Opcode 3 (store) copies the selected working register into its slot. After that edge, `busy` is high for exactly BUSY_CYCLES cycles. While `busy` is high, every command is ignored.
- R7: Opcode 4 (restore) loads the selected working register from its slot. While `reload_req` is high, all three working registers load from their slots, and any command presented in the same cycle is ignored.
- R8: While `wp_n` is low, write, step and store commands have no effect. Restore, reload and read still work.
- R9: Opcodes 1, 2 and 5 to 8 are accepted only when `cmd_addr` equals {RDAC_HI, `rdac_pins`}. Opcodes 3 and 4 are accepted only when `cmd_addr` equals {NV_HI, `nv_pins`}. Opcode 0 (no-op) changes no state at either address.
- R10: Opcodes 9 to 15, and channel number 3, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| reload_req | input | 1 | Restore all working registers from their slots |
| wp_n | input | 1 | Write protect, active low |
| rdac_pins | input | 2 | Low address bits for wiper commands |
| nv_pins | input | 2 | Low address bits for store/restore commands |
| cmd_valid | input | 1 | Command strobe |
| cmd_addr | input | 7 | Device address of the command |
| cmd_op | input | 4 | Opcode |
| cmd_chan | input | 2 | Channel number |
| cmd_data | input | 9 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 9 | Read data |
| busy | output | 1 | Store in progress |
| wiper0 | output | 9 | Channel 0 code |
| wiper1 | output | 9 | Channel 1 code |
| wiper2 | output | 7 | Channel 2 code |

## Verification
The assertions assume a few things about the inputs:
- Each command is a single-cycle strobe.
- `cmd_op` is meaningful only while `cmd_valid` is high.
- The reset pulse lasts at least one full cycle before the first command.

The stimulus drives every command for exactly one cycle on the falling edge and clears `cmd_valid` and `reload_req` straight after the rising edge. It raises `rst` for several cycles at the start. It only changes `wp_n` between commands.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

    localparam int DATA_W   = 9;
    localparam int WIDE_W   = 9;
    localparam int NARROW_W = 7;
    localparam int NCH      = 3;
    localparam int OP_W     = 4;
    localparam int CH_W     = 2;
    localparam int ADDR_W   = 7;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 4'd0,
        OP_WRITE   = 4'd1,
        OP_READ    = 4'd2,
        OP_STORE   = 4'd3,
        OP_RESTORE = 4'd4,
        OP_LIN_UP  = 4'd5,
        OP_LIN_DN  = 4'd6,
        OP_LOG_UP  = 4'd7,
        OP_LOG_DN  = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        STEP_LIN_UP,
        STEP_LIN_DN,
        STEP_LOG_UP,
        STEP_LOG_DN
    } step_e;

    typedef struct packed {
        logic [NCH-1:0]    sel;
        logic              wr;
        logic              rd;
        logic              store;
        logic              restore;
        logic              step;
        step_e             kind;
        logic [DATA_W-1:0] data;
    } action_t;

    function automatic logic [DATA_W-1:0] clamp_code(
        input logic [DATA_W-1:0] v, input logic [DATA_W-1:0] top);
        return (v > top) ? top : v;
    endfunction

    function automatic logic [DATA_W-1:0] step_code(
        input logic [DATA_W-1:0] v, input step_e k, input logic [DATA_W-1:0] top);
        logic [DATA_W:0] w;
        w = {1'b0, v};
        case (k)
            STEP_LIN_UP: w = (v >= top) ? {1'b0, top} : w + (DATA_W+1)'(1);
            STEP_LIN_DN: w = (v == '0) ? w : w - (DATA_W+1)'(1);
            STEP_LOG_UP: w = {v, 1'b1};
            default:     w = w >> 1;
        endcase
        if (w > {1'b0, top}) w = {1'b0, top};
        return w[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/wpr_decode.sv
module wpr_decode
    import wpr_pkg::*;
#(
    parameter logic [4:0] RDAC_HI = 5'b01011,
    parameter logic [4:0] NV_HI   = 5'b10100
) (
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [CH_W-1:0]   cmd_chan,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [1:0]        rdac_pins,
    input  logic [1:0]        nv_pins,
    input  logic              wp_n,
    input  logic              busy,
    input  logic              reload_req,
    output action_t           act
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH-1);

    logic hit_rdac, hit_nv, live;

    always_comb begin
        hit_rdac = (cmd_addr == {RDAC_HI, rdac_pins});
        hit_nv   = (cmd_addr == {NV_HI, nv_pins});
        live     = cmd_valid && !busy && !reload_req && (cmd_chan <= LAST_CH);
        act      = '0;
        act.data = cmd_data;
        act.sel  = live ? (NCH'(1) << cmd_chan) : '0;
        if (live) begin
            case (op_e'(cmd_op))
                OP_WRITE:   act.wr      = hit_rdac && wp_n;
                OP_READ:    act.rd      = hit_rdac;
                OP_STORE:   act.store   = hit_nv && wp_n;
                OP_RESTORE: act.restore = hit_nv;
                OP_LIN_UP: begin act.step = hit_rdac && wp_n; act.kind = STEP_LIN_UP; end
                OP_LIN_DN: begin act.step = hit_rdac && wp_n; act.kind = STEP_LIN_DN; end
                OP_LOG_UP: begin act.step = hit_rdac && wp_n; act.kind = STEP_LOG_UP; end
                OP_LOG_DN: begin act.step = hit_rdac && wp_n; act.kind = STEP_LOG_DN; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wpr_busy.sv
module wpr_busy #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (start)       cnt <= CW'(CYCLES);
        else if (cnt != '0)   cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/wpr_channel.sv
module wpr_channel
    import wpr_pkg::*;
#(
    parameter int IDX = 0,
    parameter int W   = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reload_req,
    input  action_t           act,
    output logic [DATA_W-1:0] code
);
    localparam logic [DATA_W-1:0] TOP = DATA_W'((1 << W) - 1);
    localparam logic [DATA_W-1:0] MID = DATA_W'(1 << (W - 1));

    logic [DATA_W-1:0] work, slot, nxt;
    logic              mine;

    always_comb begin
        mine = act.sel[IDX];
        nxt  = work;
        if (reload_req)                 nxt = slot;
        else if (mine && act.wr)        nxt = clamp_code(act.data, TOP);
        else if (mine && act.restore)   nxt = slot;
        else if (mine && act.step)      nxt = step_code(work, act.kind, TOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work <= MID;
            slot <= MID;
        end else begin
            work <= nxt;
            if (mine && act.store) slot <= work;
        end
    end

    assign code = work;
endmodule

// File: rtl/wiper_ctrl_top.sv
module wiper_ctrl_top
    import wpr_pkg::*;
#(
    parameter int         BUSY_CYCLES = 20,
    parameter logic [4:0] RDAC_HI     = 5'b01011,
    parameter logic [4:0] NV_HI       = 5'b10100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reload_req,
    input  logic        wp_n,
    input  logic [1:0]  rdac_pins,
    input  logic [1:0]  nv_pins,
    input  logic        cmd_valid,
    input  logic [6:0]  cmd_addr,
    input  logic [3:0]  cmd_op,
    input  logic [1:0]  cmd_chan,
    input  logic [8:0]  cmd_data,
    output logic        rd_valid,
    output logic [8:0]  rd_data,
    output logic        busy,
    output logic [8:0]  wiper0,
    output logic [8:0]  wiper1,
    output logic [6:0]  wiper2
);
    action_t           act;
    logic [DATA_W-1:0] codes [NCH];
    logic [DATA_W-1:0] rd_mux;

    wpr_decode #(.RDAC_HI(RDAC_HI), .NV_HI(NV_HI)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .cmd_op    (cmd_op),
        .cmd_chan  (cmd_chan),
        .cmd_data  (cmd_data),
        .rdac_pins (rdac_pins),
        .nv_pins   (nv_pins),
        .wp_n      (wp_n),
        .busy      (busy),
        .reload_req(reload_req),
        .act       (act)
    );

    wpr_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk  (clk),
        .rst  (rst),
        .start(act.store),
        .busy (busy)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int CW = (i == NCH - 1) ? NARROW_W : WIDE_W;
        wpr_channel #(.IDX(i), .W(CW)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .reload_req(reload_req),
            .act       (act),
            .code      (codes[i])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NCH; i++)
            if (act.sel[i]) rd_mux = codes[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= act.rd;
            if (act.rd) rd_data <= rd_mux;
        end
    end

    assign wiper0 = codes[0];
    assign wiper1 = codes[1];
    assign wiper2 = codes[2][NARROW_W-1:0];

    logic unused_hi;
    assign unused_hi = |codes[2][DATA_W-1:NARROW_W];
endmodule

// File: rtl/wpr_checker.sv
module wpr_checker #(
    parameter int BUSY_CYCLES = 20
) (
    input logic       clk,
    input logic       rst,
    input logic       reload_req,
    input logic       wp_n,
    input logic       cmd_valid,
    input logic [3:0] cmd_op,
    input logic       rd_valid,
    input logic       busy,
    input logic [8:0] wiper0,
    input logic [8:0] wiper1,
    input logic [6:0] wiper2
);
    logic [1:0] warm;
    int         run;

    always_ff @(posedge clk) begin
        if (rst) warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) run <= 0;
        else if (busy) run <= run + 1;
        else begin
            if (run != 0)
                assert_busy_len_R6: assert (run == BUSY_CYCLES);
            run <= 0;
        end
    end

    assert_busy_rise_R6: assert property (@(posedge clk) disable iff (rst || warm != 2'd3)
        $rose(busy) |-> $past(cmd_valid && cmd_op == 4'd3));

    assert_busy_freeze_R6: assert property (@(posedge clk) disable iff (rst || warm != 2'd3)
        $past(busy && !reload_req) |-> ($stable(wiper0) && $stable(wiper1) && $stable(wiper2)));

    assert_rd_src_R3: assert property (@(posedge clk) disable iff (rst || warm != 2'd3)
        rd_valid |-> $past(cmd_valid && cmd_op == 4'd2));

    assert_wp_freeze_R8: assert property (@(posedge clk) disable iff (rst || warm != 2'd3)
        ($past(!wp_n && !reload_req) && !$past(cmd_valid && cmd_op == 4'd4))
        |-> ($stable(wiper0) && $stable(wiper1) && $stable(wiper2)));

    assert_nop_quiet_R9: assert property (@(posedge clk) disable iff (rst || warm != 2'd3)
        $past(cmd_valid && cmd_op == 4'd0 && !reload_req)
        |-> ($stable(wiper0) && $stable(wiper1) && $stable(wiper2) && !rd_valid));
endmodule

bind wiper_ctrl_top wpr_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reload_req(reload_req),
    .wp_n      (wp_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .rd_valid  (rd_valid),
    .busy      (busy),
    .wiper0    (wiper0),
    .wiper1    (wiper1),
    .wiper2    (wiper2)
);

// File: tb/sim_wiper_ctrl_top.sv
module sim_wiper_ctrl_top;
    localparam int NB = 4;
    localparam logic [6:0] RA = {5'b01011, 2'b10};
    localparam logic [6:0] NA = {5'b10100, 2'b01};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reload_req = 1'b0;
    logic       wp_n = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [6:0] cmd_addr = '0;
    logic [3:0] cmd_op = '0;
    logic [1:0] cmd_chan = '0;
    logic [8:0] cmd_data = '0;
    logic       rd_valid, busy;
    logic [8:0] rd_data, wiper0, wiper1;
    logic [6:0] wiper2;

    int n_run = 0, n_fail = 0;
    int ew [3];
    int ens[3];
    int busy_left = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wiper_ctrl_top #(.BUSY_CYCLES(NB)) u0 (
        .clk(clk), .rst(rst), .reload_req(reload_req), .wp_n(wp_n),
        .rdac_pins(2'b10), .nv_pins(2'b01), .cmd_valid(cmd_valid),
        .cmd_addr(cmd_addr), .cmd_op(cmd_op), .cmd_chan(cmd_chan),
        .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .wiper0(wiper0), .wiper1(wiper1), .wiper2(wiper2)
    );

    function automatic int topv(input int c);
        return (c == 2) ? 127 : 511;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_state(input string tag, input bit rdx, input int rdv);
        chk(tag, "wiper0", int'(wiper0), ew[0]);
        chk(tag, "wiper1", int'(wiper1), ew[1]);
        chk(tag, "wiper2", int'(wiper2), ew[2]);
        chk(tag, "busy", int'(busy), int'(busy_left != 0));
        chk(tag, "rd_valid", int'(rd_valid), int'(rdx));
        if (rdx) chk(tag, "rd_data", int'(rd_data), rdv);
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic send(input string tag, input int op, input int ch, input int data,
                        input logic [6:0] addr, input bit rl);
        bit ok, rdx, st;
        int rdv, t, v;
        cmd_valid = 1'b1; cmd_op = 4'(op); cmd_chan = 2'(ch);
        cmd_data = 9'(data); cmd_addr = addr; reload_req = rl;
        rdx = 0; st = 0; rdv = 0;
        ok = (busy_left == 0) && !rl && ch < 3;
        if (rl) for (int i = 0; i < 3; i++) ew[i] = ens[i];
        else if (ok) begin
            t = topv(ch); v = ew[ch];
            case (op)
                1: if (addr == RA && wp_n) ew[ch] = (data > t) ? t : data;
                2: if (addr == RA) begin rdx = 1; rdv = v; end
                3: if (addr == NA && wp_n) begin ens[ch] = v; st = 1; end
                4: if (addr == NA) ew[ch] = ens[ch];
                5: if (addr == RA && wp_n) ew[ch] = (v == t) ? t : v + 1;
                6: if (addr == RA && wp_n) ew[ch] = (v == 0) ? 0 : v - 1;
                7: if (addr == RA && wp_n) ew[ch] = (2*v + 1 > t) ? t : 2*v + 1;
                8: if (addr == RA && wp_n) ew[ch] = v / 2;
                default: ;
            endcase
        end
        busy_left = st ? NB : ((busy_left > 0) ? busy_left - 1 : 0);
        @(posedge clk); #1;
        cmd_valid = 1'b0; reload_req = 1'b0;
        @(negedge clk);
        check_state(tag, rdx, rdv);
    endtask

    task automatic idle(input string tag, input int n);
        for (int k = 0; k < n; k++) begin
            busy_left = (busy_left > 0) ? busy_left - 1 : 0;
            @(negedge clk);
            check_state(tag, 0, 0);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            ew[i] = (i == 2) ? 64 : 256;
            ens[i] = ew[i];
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1", 0, 0);

        // R2 / R3: every code on every channel, written then read back
        for (int c = 0; c < 3; c++)
            for (int v = 0; v < 512; v++) begin
                send("R2", 1, c, v, RA, 0);
                send("R3", 2, c, 0, RA, 0);
            end

        // R4: linear steps from every code
        for (int c = 0; c < 3; c++)
            for (int v = 0; v <= topv(c); v++) begin
                send("R4", 1, c, v, RA, 0); send("R4", 5, c, 0, RA, 0);
                send("R4", 1, c, v, RA, 0); send("R4", 6, c, 0, RA, 0);
            end

        // R5: logarithmic steps from every code
        for (int c = 0; c < 3; c++)
            for (int v = 0; v <= topv(c); v++) begin
                send("R5", 1, c, v, RA, 0); send("R5", 7, c, 0, RA, 0);
                send("R5", 1, c, v, RA, 0); send("R5", 8, c, 0, RA, 0);
            end

        // R6: store, busy window, commands ignored while busy
        send("R6", 1, 0, 100, RA, 0);
        send("R6", 3, 0, 0, NA, 0);
        send("R6", 1, 0, 5, RA, 0);
        send("R6", 3, 1, 0, NA, 0);
        idle("R6", NB);
        send("R6", 1, 0, 7, RA, 0);
        send("R6", 4, 0, 0, NA, 0);

        // R7: restore per channel, reload pin with a competing command
        send("R7", 1, 2, 10, RA, 0);
        send("R7", 3, 2, 0, NA, 0);
        idle("R7", NB);
        send("R7", 1, 0, 33, RA, 0);
        send("R7", 1, 1, 44, RA, 0);
        send("R7", 1, 2, 55, RA, 0);
        send("R7", 1, 0, 400, RA, 1);
        send("R7", 1, 2, 99, RA, 0);
        send("R7", 4, 2, 0, NA, 0);

        // R8: write protect
        send("R8", 1, 1, 123, RA, 0);
        wp_n = 1'b0;
        send("R8", 1, 1, 9, RA, 0);
        send("R8", 5, 1, 0, RA, 0);
        send("R8", 7, 1, 0, RA, 0);
        send("R8", 3, 1, 0, NA, 0);
        send("R8", 2, 1, 0, RA, 0);
        send("R8", 4, 1, 0, NA, 0);
        send("R8", 1, 0, 1, RA, 1);
        send("R9", 0, 0, 0, RA, 0);
        wp_n = 1'b1;
        idle("R8", 2);

        // R9: device addressing and no-op
        send("R9", 1, 0, 77, NA, 0);
        send("R9", 1, 0, 78, {5'b01011, 2'b01}, 0);
        send("R9", 2, 0, 0, NA, 0);
        send("R9", 3, 0, 0, RA, 0);
        send("R9", 4, 0, 0, RA, 0);
        send("R9", 1, 0, 79, RA, 0);
        send("R9", 0, 0, 300, RA, 0);
        send("R9", 0, 1, 300, NA, 0);

        // R10: unknown opcodes and channel 3
        for (int op = 9; op < 16; op++) begin
            send("R10", op, 0, 200, RA, 0);
            send("R10", op, 1, 200, NA, 0);
        end
        send("R10", 1, 3, 17, RA, 0);
        send("R10", 2, 3, 0, RA, 0);
        send("R10", 3, 3, 0, NA, 0);
        idle("R10", 2);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule